// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This block gathers the event sources of a serial port into one sticky status register, fourteen bits wide. Each bit has its own enable, and a single active-high level interrupt goes to the host. The sources are one-cycle pulses from the FIFOs, the receiver, the transmitter and the break timer. These pulses come into the block on `evt_i`. A CTS toggle is the one source made inside the block: the raw CTS pin is synchronised through two flops, and any edge seen after that synchroniser sets the toggle bit.

Software reaches the block through a simple synchronous register port. At address 0 the status register reads back, and writing there clears only the bits written as one. Software acknowledges events by writing back the value it has just read. At address 1 the enable mask can be read and written. At address 2 the synchronised CTS level can be read. The interrupt line stays high as long as any set status bit is also enabled.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted and straight after it, the status register and the enable register both read zero and `irq_o` is low.
- R2: A pulse on `evt_i[n]` sets status bit n on the next clock edge, for every n except 10, and the bit then stays set until software clears it. The bit map is: 0 TX data empty, 1 RX data full, 2 TX FIFO almost empty, 3 TX FIFO empty, 4 RX FIFO almost full, 5 RX FIFO full, 6 TX underrun, 7 RX overrun, 8 parity error, 9 frame error, 10 CTS toggle, 11 RX timeout, 12 break done, 13 bus error.
- R3: A write to address 0 clears exactly those status bits whose `reg_wdata` bit is 1. All other bits keep their value.
- R4: A status bit that receives an event in the same cycle as a clear write to that bit is set after the edge.
- R5: A write to address 1 loads the enable register from `reg_wdata` on that edge. A read at address 1 returns the enable value.
- R6: `irq_o` is high exactly when some bit is set in both the status register and the enable register. It follows the registered state within the same cycle.
- R7: A read at address 2 returns the synchronised CTS level in bit 4 and zero in all other bits. A change on `cts_i` shows up in that bit after the second clock edge.
- R8: A change of either polarity on `cts_i` sets status bit 10 on the third clock edge after the change. `evt_i[10]` has no effect.
- R9: Filling the synchroniser after reset sets no CTS toggle, whatever level `cts_i` holds.
- R10: Writes to addresses 2 and 3 change no register, and a read at address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | Event pulses, one bit per source (bit 10 unused) |
| cts_i | input | 1 | Asynchronous CTS pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 line level, 3 reserved |
| reg_wdata | input | 14 | Write data |
| reg_rdata | output | 14 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The hardest case to produce is a collision: one status bit receives a new event in the same cycle that software clears it. A second hard case is the CTS toggle that comes out of the synchroniser three edges after the pin moves. This means a clear written at the wrong moment can hide an edge. The bench lines up a clear write with an event pulse on the same bit. It also moves CTS right after reset and then again while clear writes are in flight. A long stretch of pseudo-random events, writes, addresses and CTS levels is compared every cycle against a behavioural model that keeps CTS history in a queue.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int unsigned SRC_W = 14;
    localparam int unsigned CTS_TOG_BIT = 10;
    localparam int unsigned CTS_LVL_BIT = 4;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_ENABLE = 2'd1,
        ADDR_LINE   = 2'd2,
        ADDR_RSVD   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/uirq_cts_sync.sv
module uirq_cts_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_i,
    output logic level_o,
    output logic toggle_o
);
    localparam int unsigned CW    = $clog2(SYNC_STAGES + 2);
    localparam int unsigned PRIME = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
        logic [CW-1:0]          cnt;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh = {st_q.sh[SYNC_STAGES-2:0], cts_i};
        st_d.prev = st_q.sh[SYNC_STAGES-1];
        if (st_q.cnt != CW'(PRIME)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o  = st_q.sh[SYNC_STAGES-1];
    assign toggle_o = (st_q.cnt == CW'(PRIME)) && (st_q.sh[SYNC_STAGES-1] != st_q.prev);

    // R9: no toggle while the chain is still filling after reset
    a_r9_no_prime_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != CW'(PRIME)) |-> !toggle_o);

    generate
        if (SYNC_STAGES == 2) begin : g_lvl_chk
            // R7: level equals the pin value two edges earlier
            a_r7_level_delay: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.cnt >= CW'(2)) |-> (level_o == $past(cts_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] status_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] status;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the event term is ORed in last, so a set beats a clear in the same cycle
        st_d.status = (st_q.status & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign irq_o    = |(st_q.status & en_i);

    // R2, R4: every pulsed bit is set after the edge
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.status & $past(evt_i)) == $past(evt_i)));

    // R3: cleared bits without a new event are zero after the edge
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((st_q.status & $past(clr_i & ~evt_i)) == '0));

    // R2: bits not cleared keep their value
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st_q.status | $past(clr_i)) & $past(st_q.status)) == $past(st_q.status)));

    // R6: no interrupt when nothing is enabled
    a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/uirq_regfile.sv
module uirq_regfile
    import uirq_pkg::*;
#(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] status_i,
    input  logic         cts_lvl_i,
    output logic [W-1:0] enable_o,
    output logic [W-1:0] clr_o,
    output logic [W-1:0] rdata_o
);
    typedef struct packed {
        logic [W-1:0] enable;
    } rf_t;

    rf_t st_d, st_q;
    logic wr_en;

    assign wr_en = wr_i && (addr_i == ADDR_ENABLE);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.enable = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_i && (addr_i == ADDR_STATUS)) begin
            clr_o = wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (reg_addr_e'(addr_i))
            ADDR_STATUS: rdata_o = status_i;
            ADDR_ENABLE: rdata_o = st_q.enable;
            ADDR_LINE:   rdata_o[CTS_LVL_BIT] = cts_lvl_i;
            default:     rdata_o = '0;
        endcase
    end

    assign enable_o = st_q.enable;

    // R5: an enable write lands on the next edge
    a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (enable_o == $past(wdata_i)));

    // R10: the enable register holds without a write to its address
    a_r10_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable_o));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt_i,
    input  logic             cts_i,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [SRC_W-1:0] reg_wdata,
    output logic [SRC_W-1:0] reg_rdata,
    output logic             irq_o
);
    logic             cts_lvl;
    logic             cts_tog;
    logic [SRC_W-1:0] evt_eff;
    logic [SRC_W-1:0] clr;
    logic [SRC_W-1:0] enable;
    logic [SRC_W-1:0] status;

    uirq_cts_sync #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_i    (cts_i),
        .level_o  (cts_lvl),
        .toggle_o (cts_tog)
    );

    always_comb begin
        evt_eff = evt_i;
        evt_eff[CTS_TOG_BIT] = cts_tog;
    end

    uirq_status #(.W(SRC_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_eff),
        .clr_i    (clr),
        .en_i     (enable),
        .status_o (status),
        .irq_o    (irq_o)
    );

    uirq_regfile #(.W(SRC_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .status_i  (status),
        .cts_lvl_i (cts_lvl),
        .enable_o  (enable),
        .clr_o     (clr),
        .rdata_o   (reg_rdata)
    );

    // R1: right after reset nothing is pending
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && status == '0 && enable == '0));
endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] evt_i = '0;
    logic        cts_i = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [13:0] reg_wdata = '0;
    logic [13:0] reg_rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cts_i(cts_i),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // behavioural reference
    logic [13:0] m_stat, m_en;
    bit          cts_hist[$];
    int          nsamp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = '0;
            m_en   = '0;
            cts_hist.delete();
            nsamp  = 0;
        end else begin
            logic [13:0] ev;
            logic [13:0] cl;
            ev = evt_i;
            ev[10] = 1'b0;
            if (nsamp >= 3 && cts_hist[1] != cts_hist[2]) ev[10] = 1'b1;
            cl = (reg_wr && reg_addr == 2'd0) ? reg_wdata : 14'h0;
            m_stat = (m_stat & ~cl) | ev;
            if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata;
            cts_hist.push_front(cts_i);
            if (cts_hist.size() > 4) void'(cts_hist.pop_back());
            if (nsamp < 10) nsamp++;
        end
    end

    function automatic logic [13:0] m_read(input logic [1:0] a);
        logic [13:0] r;
        r = '0;
        case (a)
            2'd0: r = m_stat;
            2'd1: r = m_en;
            2'd2: r[4] = (nsamp >= 2) ? cts_hist[1] : 1'b0;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [13:0] act, input logic [13:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic [13:0] e;
        string tg;
        e = m_read(reg_addr);
        tg = (reg_addr == 2'd0) ? "R2/R3 status" : (reg_addr == 2'd1) ? "R5 enable" :
             (reg_addr == 2'd2) ? "R7 line" : "R10 reserved";
        chk(reg_rdata == e, tg, reg_rdata, e);
        chk(irq_o == |(m_stat & m_en), "R6 irq", {13'b0, irq_o}, {13'b0, |(m_stat & m_en)});
    endtask

    task automatic cyc(input logic [13:0] ev, input bit wr, input logic [1:0] a,
                       input logic [13:0] wd, input bit c);
        @(negedge clk);
        if (rst_n) compare_model();
        evt_i = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd; cts_i = c;
    endtask

    // read address a with no other activity and compare to a fixed value
    task automatic look(input logic [1:0] a, input logic [13:0] exp, input bit c, input string tag);
        cyc('0, 0, a, '0, c);
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(reg_rdata == 14'h0, "R1 status in reset", reg_rdata, 14'h0);
        chk(irq_o == 1'b0, "R1 irq in reset", {13'b0, irq_o}, 14'h0);
        rst_n = 1'b1;
        look(2'd0, 14'h0, 1, "R1 status after reset");
        look(2'd1, 14'h0, 1, "R1 enable after reset");
        repeat (5) cyc('0, 0, 2'd0, '0, 1);
        look(2'd0, 14'h0, 1, "R9 no toggle from priming");
        look(2'd2, 14'h0010, 1, "R7 level high");

        // R2, R8: pulse each source in turn, bit 10 must not stick
        for (int i = 0; i < 14; i++) cyc(14'(1) << i, 0, 2'd0, '0, 1);
        cyc('0, 0, 2'd0, '0, 1);
        look(2'd0, 14'h3BFF, 1, "R2 all sources sticky, R8 evt bit 10 ignored");

        // R3: partial clear
        cyc('0, 1, 2'd0, 14'h000F, 1);
        look(2'd0, 14'h3BF0, 1, "R3 write-1-to-clear");

        // R4: clear bits 4,5 while bit 4 sees an event
        cyc(14'h0010, 1, 2'd0, 14'h0030, 1);
        look(2'd0, 14'h3BD0, 1, "R4 set wins over clear");

        // R5, R6
        cyc('0, 1, 2'd1, 14'h0400, 1);
        look(2'd1, 14'h0400, 1, "R5 enable readback");
        #1 chk(irq_o == 1'b0, "R6 enabled bit not set", {13'b0, irq_o}, 14'h0);

        // R7, R8: CTS falls
        cyc('0, 0, 2'd2, '0, 0);
        cyc('0, 0, 2'd2, '0, 0);
        cyc('0, 0, 2'd2, '0, 0);
        #1 chk(reg_rdata == 14'h0, "R7 level low after two edges", reg_rdata, 14'h0);
        look(2'd0, 14'h3FD0, 0, "R8 toggle set on third edge");
        #1 chk(irq_o == 1'b1, "R6 irq on enabled toggle", {13'b0, irq_o}, 14'h1);

        // full acknowledge
        cyc('0, 1, 2'd0, 14'h3FFF, 0);
        look(2'd0, 14'h0, 0, "R3 full clear");
        #1 chk(irq_o == 1'b0, "R6 irq drops", {13'b0, irq_o}, 14'h0);

        // R10: writes to line and reserved addresses
        cyc(14'h0, 1, 2'd2, 14'h3FFF, 0);
        cyc(14'h0, 1, 2'd3, 14'h3FFF, 0);
        look(2'd1, 14'h0400, 0, "R10 enable untouched");
        look(2'd0, 14'h0, 0, "R10 status untouched");
        look(2'd3, 14'h0, 0, "R10 reserved reads zero");

        // enable all, bus error source
        cyc('0, 1, 2'd1, 14'h3FFF, 0);
        cyc(14'h2000, 0, 2'd0, '0, 0);
        cyc('0, 0, 2'd0, '0, 0);
        #1 chk(irq_o == 1'b1, "R6 bus error interrupt", {13'b0, irq_o}, 14'h1);

        // CTS rises while a clear of bit 10 is in flight
        cyc('0, 0, 2'd0, '0, 1);
        cyc('0, 1, 2'd0, 14'h0400, 1);
        cyc('0, 1, 2'd0, 14'h0400, 1);
        look(2'd0, 14'h2400, 1, "R4 toggle beats clear");

        // pseudo-random traffic checked by the model each cycle
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            cyc((r[3:0] == 4'd0) ? r[17:4] : 14'h0, r[18] & r[19], r[21:20],
                14'($urandom), (r[31:27] == 5'd0) ? ~cts_i : cts_i);
        end
        cyc('0, 0, 2'd0, '0, cts_i);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule